// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block gives a processor three independent 16-bit down-counters behind one byte-wide register port. Each channel has its own count clock, gate and output. The host reaches a channel's count by address, and programs a channel through a shared control register. The control value names the channel, how the count is loaded and read (low byte, high byte, or low then high), the counting mode, and binary or four-digit decimal counting. A special control value freezes a channel's count so software can read a stable value while the counter keeps running.

Two modes are built. The one-shot mode drives the output low and raises it when the count expires. The rate mode produces a periodic one-tick low pulse every N ticks. All logic runs on one system clock. The count clocks are sampled on that clock, and each rising edge seen on a count clock is one count tick. A bus access lasts one system-clock cycle while its strobe and chip select are low.

Top module: `interval_timer`

## Requirements
- R1: After reset every channel output is low, every count reads 0x00, each channel is in one-shot binary mode with low-then-high access, and `dout_oe` is low.
- R2: An access takes effect only in a cycle where `cs_n` is low. In that cycle a low `wr_n` writes and a low `rd_n` reads. Address 0, 1 or 2 selects that channel's count and address 3 selects the control register. `dout_oe` is high exactly in read cycles. A write with `cs_n` high changes nothing.
- R3: The control byte is laid out as follows. Bits [7:6] select the channel, and value 3 is ignored. Bits [5:4] give the access: 00 latch, 01 low byte only, 10 high byte only, 11 low then high. Bits [3:1] give the mode. Bit 0 selects decimal counting. Mode 0 is one-shot, and modes 2 and 6 are rate. A control byte naming any other mode is ignored.
- R4: With low-then-high access, a load takes two count writes, low byte first. A low-only load clears the high byte, and a high-only load clears the low byte.
- R5: A count tick is a rising edge of `ch_clk[i]` sampled by `clk`. The first tick after a load completes copies the load into the counter. Later ticks decrement the counter only while `ch_gate[i]` is high.
- R6: In one-shot mode the output goes low when the control byte is written or a load completes. It goes high on the tick that takes the count from 1 to 0, and it stays high while the count wraps and keeps running.
- R7: In rate mode the output is high after the control byte is written. It is low for the one tick period during which the count is 1. The next tick reloads the counter and raises the output, so the period is N ticks. While the gate is low the count holds and the output is high.
- R8: In rate mode, a load written while the counter runs takes effect only at the next reload.
- R9: Decimal counting decrements four BCD digits with borrow, so 0100 becomes 0099 and 0000 becomes 9999. A load of zero therefore counts 10000 ticks in decimal and 65536 in binary.
- R10: Reading a channel returns the live count. With low-then-high access, successive reads return the low byte then the high byte. With byte-only access, each read returns that byte.
- R11: A latch command snapshots the count. Reads return the snapshot until it is fully read, which means its high byte under low-then-high access or its one byte otherwise. Further latch commands are ignored until then.
- R12: When a latch command and a count tick fall in the same cycle, the snapshot holds the count before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Channel (0-2) or control register (3) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | High when read data is driven |
| ch_clk | input | 3 | Per-channel count clock |
| ch_gate | input | 3 | Per-channel gate |
| ch_out | output | 3 | Per-channel output |

## Verification
A latch command arriving from the bus and a count tick arriving from the channel clock can land on the same system-clock edge, and the snapshot must then hold the pre-tick count. The bench provokes this by raising a channel's count clock in the very cycle it writes the latch command. It then reads the snapshot and expects the old value, and a further live read must show the decremented count. A mode-0 reload that completes on the same edge as a terminal-count tick is also ordered, with the load winning and the output held low.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int NCH   = 3;
    localparam int CNT_W = 16;
    localparam int DIGS  = CNT_W / 4;
    localparam logic [1:0] CTL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_s;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } chcfg_s;

    function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic borrow;
        if (!bcd) return v - 1'b1;
        borrow = 1'b1;
        for (int d = 0; d < DIGS; d++) begin
            if (!borrow) begin
                r[d*4 +: 4] = v[d*4 +: 4];
            end else if (v[d*4 +: 4] == 4'd0) begin
                r[d*4 +: 4] = 4'd9;
                borrow = 1'b1;
            end else begin
                r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                borrow = 1'b0;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pit_decode.sv
module pit_decode
    import pit_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [1:0]     addr,
    input  logic [7:0]     din,
    output logic [NCH-1:0] cfg_we,
    output logic [NCH-1:0] latch,
    output logic [NCH-1:0] wr_byte,
    output logic [NCH-1:0] rd_byte,
    output chcfg_s         cfg,
    output logic           oe
);
    ctrl_s cw;
    logic  wr_act, rd_act, is_ctl, mode_ok;

    assign cw      = ctrl_s'(din);
    assign wr_act  = !cs_n && !wr_n;
    assign rd_act  = !cs_n && !rd_n;
    assign is_ctl  = (addr == CTL_ADDR);
    assign mode_ok = (cw.mode == 3'd0) || (cw.mode[1:0] == 2'b10);
    assign cfg     = '{acc: cw.acc, mode: cw.mode, bcd: cw.bcd};
    assign oe      = rd_act;

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        logic hit;
        assign hit        = wr_act && is_ctl && (cw.sel == 2'(i));
        assign wr_byte[i] = wr_act && (addr == 2'(i));
        assign rd_byte[i] = rd_act && (addr == 2'(i));
        assign latch[i]   = hit && (cw.acc == ACC_LATCH);
        assign cfg_we[i]  = hit && (cw.acc != ACC_LATCH) && mode_ok;
    end

    // R2
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_act && rd_act) |-> $onehot0({cfg_we, latch, wr_byte, rd_byte}));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  chcfg_s     cfg_in,
    input  logic       latch_cmd,
    input  logic       wr_byte,
    input  logic       rd_byte,
    input  logic [7:0] din,
    input  logic       tick,
    input  logic       gate,
    output logic [7:0] dout,
    output logic       out
);
    chcfg_s           cfg;
    logic [CNT_W-1:0] ce, cr, olatch, rd_src, dec;
    logic [7:0]       lo_buf;
    logic             latched, wptr, rptr, armed, loadpend, tick_q;
    logic             step, rate, hi_sel, read_last;

    assign step      = tick && !tick_q;
    assign rate      = cfg.mode[1];
    assign dec       = cnt_dec(ce, cfg.bcd);
    assign rd_src    = latched ? olatch : ce;
    assign hi_sel    = (cfg.acc == ACC_HI) || (cfg.acc == ACC_WORD && rptr);
    assign dout      = hi_sel ? rd_src[15:8] : rd_src[7:0];
    assign read_last = rd_byte && (cfg.acc != ACC_WORD || rptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '{acc: ACC_WORD, mode: 3'd0, bcd: 1'b0};
            ce       <= '0;
            cr       <= '0;
            olatch   <= '0;
            lo_buf   <= '0;
            latched  <= 1'b0;
            wptr     <= 1'b0;
            rptr     <= 1'b0;
            armed    <= 1'b0;
            loadpend <= 1'b0;
            tick_q   <= 1'b0;
            out      <= 1'b0;
        end else begin
            tick_q <= tick;
            if (cfg_we) begin
                cfg      <= cfg_in;
                wptr     <= 1'b0;
                rptr     <= 1'b0;
                latched  <= 1'b0;
                armed    <= 1'b0;
                loadpend <= 1'b0;
                out      <= cfg_in.mode[1];
            end else begin
                // counting side first, so a load completing in the same cycle wins
                if (rate && !gate) begin
                    out <= 1'b1;
                end
                if (step) begin
                    if (loadpend) begin
                        ce       <= cr;
                        loadpend <= 1'b0;
                    end else if (armed && gate) begin
                        if (rate) begin
                            if (ce == 16'd2) begin
                                ce  <= 16'd1;
                                out <= 1'b0;
                            end else if (ce == 16'd1) begin
                                ce  <= cr;
                                out <= 1'b1;
                            end else begin
                                ce <= dec;
                            end
                        end else begin
                            ce <= dec;
                            if (ce == 16'd1) out <= 1'b1;
                        end
                    end
                end
                // bus side
                if (latch_cmd && !latched) begin
                    olatch  <= ce;
                    latched <= 1'b1;
                end
                if (rd_byte) begin
                    if (cfg.acc == ACC_WORD) rptr <= !rptr;
                    if (read_last) latched <= 1'b0;
                end
                if (wr_byte) begin
                    if (cfg.acc == ACC_WORD && !wptr) begin
                        lo_buf <= din;
                        wptr   <= 1'b1;
                    end else begin
                        unique case (cfg.acc)
                            ACC_LO:  cr <= {8'h00, din};
                            ACC_HI:  cr <= {din, 8'h00};
                            default: cr <= {din, lo_buf};
                        endcase
                        wptr  <= 1'b0;
                        armed <= 1'b1;
                        if (!rate || !armed) loadpend <= 1'b1;
                        if (!rate) out <= 1'b0;
                    end
                end
            end
        end
    end

    // R7
    rate_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rate && !out) |-> (ce == 16'd1));

    // R6
    oneshot_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (!rate && out) |-> (armed && !loadpend));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (rate && armed && !loadpend && gate && step && ce == 16'd1 && !cfg_we && !wr_byte)
        |=> (ce == $past(cr)));

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (latched && !cfg_we && !rd_byte) |=> (latched && $stable(olatch)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import pit_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [1:0]     addr,
    input  logic [7:0]     din,
    output logic [7:0]     dout,
    output logic           dout_oe,
    input  logic [NCH-1:0] ch_clk,
    input  logic [NCH-1:0] ch_gate,
    output logic [NCH-1:0] ch_out
);
    logic [NCH-1:0] cfg_we, latch, wr_byte, rd_byte;
    chcfg_s         cfg;
    logic [7:0]     ch_dout [NCH];

    pit_decode u_dec (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .cfg_we(cfg_we), .latch(latch),
        .wr_byte(wr_byte), .rd_byte(rd_byte), .cfg(cfg), .oe(dout_oe)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pit_channel u_ch (
            .clk(clk), .rst(rst), .cfg_we(cfg_we[i]), .cfg_in(cfg),
            .latch_cmd(latch[i]), .wr_byte(wr_byte[i]), .rd_byte(rd_byte[i]),
            .din(din), .tick(ch_clk[i]), .gate(ch_gate[i]),
            .dout(ch_dout[i]), .out(ch_out[i])
        );
    end

    always_comb begin
        dout = 8'h00;
        if (dout_oe) begin
            unique case (addr)
                2'd0:    dout = ch_dout[0];
                2'd1:    dout = ch_dout[1];
                2'd2:    dout = ch_dout[2];
                default: dout = 8'h00;
            endcase
        end
    end
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
    localparam int CLK_P = 10;

    logic       clk = 0, rst = 1, cs_n = 1, rd_n = 1, wr_n = 1;
    logic [1:0] addr = 0;
    logic [7:0] din = 0, dout;
    logic       dout_oe;
    logic [2:0] ch_clk = 0, ch_gate = 3'b111, ch_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = !clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .ch_clk(ch_clk), .ch_gate(ch_gate), .ch_out(ch_out)
    );

    // monitor: pops expected read data and compares in the read cycle
    always @(negedge clk) begin
        if (!cs_n && !rd_n) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL read with no expectation: got %h", dout);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (dout !== e || dout_oe !== 1'b1) begin
                    n_fail++;
                    $display("FAIL %s: read %h oe %b, expected %h oe 1", t, dout, dout_oe, e);
                end
            end
        end
    end

    task automatic chk(string t, logic [7:0] act, logic [7:0] e);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: got %h, expected %h", t, act, e);
        end
    endtask

    task automatic chk_out(string t, int ch, logic e);
        @(negedge clk);
        chk(t, {7'd0, ch_out[ch]}, {7'd0, e});
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 0; wr_n = 0; addr = a; din = d;
        @(posedge clk); #1;
        cs_n = 1; wr_n = 1;
    endtask

    task automatic wr_nocs(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 1; wr_n = 0; addr = a; din = d;
        @(posedge clk); #1;
        wr_n = 1;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        cs_n = 0; rd_n = 0; addr = a;
        @(posedge clk); #1;
        cs_n = 1; rd_n = 1;
    endtask

    task automatic tk(int ch);
        @(posedge clk); #1;
        ch_clk[ch] = 1;
        @(posedge clk); #1;
        ch_clk[ch] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        @(negedge clk);
        chk("R1 outputs", {5'd0, ch_out}, 8'h00);
        chk("R1 dout_oe idle", {7'd0, dout_oe}, 8'h00);
        rd(0, 8'h00, "R1 count lo");
        rd(0, 8'h00, "R1 count hi");

        // R6/R5/R10 one-shot binary on channel 0
        wr(3, 8'h30);
        chk_out("R6 low after control", 0, 0);
        wr(0, 8'h03); wr(0, 8'h00);
        tk(0); chk_out("R5 load tick out", 0, 0);
        ch_gate[0] = 0;
        tk(0);
        rd(0, 8'h03, "R5 gate low holds lo");
        rd(0, 8'h00, "R10 word read hi");
        ch_gate[0] = 1;
        tk(0); tk(0); chk_out("R6 count 1 still low", 0, 0);
        tk(0); chk_out("R6 terminal count high", 0, 1);
        tk(0); chk_out("R6 stays high after wrap", 0, 1);
        rd(0, 8'hFF, "R6 wrap lo");
        rd(0, 8'hFF, "R6 wrap hi");
        // R2 no effect without chip select
        wr_nocs(3, 8'h30);
        chk_out("R2 write without cs ignored", 0, 1);
        // R3 unsupported mode ignored
        wr(3, 8'h32);
        chk_out("R3 mode 1 ignored", 0, 1);

        // R7/R8 rate mode on channel 1
        wr(3, 8'h74);
        chk_out("R7 high after control", 1, 1);
        wr(1, 8'h03); wr(1, 8'h00);
        tk(1); chk_out("R7 load", 1, 1);
        tk(1); chk_out("R7 count 2", 1, 1);
        tk(1); chk_out("R7 count 1 low", 1, 0);
        tk(1); chk_out("R7 reload high", 1, 1);
        tk(1); tk(1); chk_out("R7 second period low", 1, 0);
        wr(1, 8'h05); wr(1, 8'h00);
        chk_out("R8 running load no restart", 1, 0);
        tk(1); chk_out("R8 reload high", 1, 1);
        rd(1, 8'h05, "R8 new count at reload lo");
        rd(1, 8'h00, "R8 new count at reload hi");
        tk(1);
        ch_gate[1] = 0;
        tk(1); chk_out("R7 gate low output high", 1, 1);
        rd(1, 8'h04, "R7 gate low holds lo");
        rd(1, 8'h00, "R7 gate low holds hi");
        ch_gate[1] = 1;
        // R3 mode 6 acts as rate mode
        wr(3, 8'h7C);
        wr(1, 8'h02); wr(1, 8'h00);
        tk(1); tk(1); chk_out("R3 mode 6 pulse low", 1, 0);
        tk(1); chk_out("R3 mode 6 reload", 1, 1);

        // R9 decimal counting on channel 2
        wr(3, 8'hB1);
        wr(2, 8'h00); wr(2, 8'h00);
        tk(2); tk(2);
        rd(2, 8'h99, "R9 zero wraps to 9999 lo");
        rd(2, 8'h99, "R9 zero wraps to 9999 hi");
        wr(2, 8'h00); wr(2, 8'h01);
        tk(2); tk(2);
        rd(2, 8'h99, "R9 borrow lo");
        rd(2, 8'h00, "R9 borrow hi");

        // R4/R10 byte-only loads
        wr(3, 8'h90);
        wr(2, 8'h25);
        tk(2);
        rd(2, 8'h25, "R4 low only");
        rd(2, 8'h25, "R10 low only repeat");
        wr(3, 8'hA0);
        wr(2, 8'h12);
        tk(2);
        rd(2, 8'h12, "R4 high only");
        tk(2);
        rd(2, 8'h11, "R10 high only after tick");

        // R11 latch
        wr(3, 8'hB0);
        wr(2, 8'h00); wr(2, 8'h01);
        tk(2);
        wr(3, 8'h80);
        tk(2);
        wr(3, 8'h80);
        tk(2);
        rd(2, 8'h00, "R11 snapshot lo");
        rd(2, 8'h01, "R11 snapshot hi");
        rd(2, 8'hFE, "R11 live after release lo");
        rd(2, 8'h00, "R11 live after release hi");

        // R12 latch and tick in the same cycle
        @(posedge clk); #1;
        cs_n = 0; wr_n = 0; addr = 3; din = 8'h80; ch_clk[2] = 1;
        @(posedge clk); #1;
        cs_n = 1; wr_n = 1; ch_clk[2] = 0;
        rd(2, 8'hFE, "R12 pre-tick snapshot lo");
        rd(2, 8'h00, "R12 pre-tick snapshot hi");
        rd(2, 8'hFD, "R12 live count lo");
        rd(2, 8'h00, "R12 live count hi");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard left %0d expected reads", exp_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule